// File: doc/BRIEF.md
# Clock-Phase Synchronising Bridge for a Slow Byte Register File

This block joins a fast 16-bit processor bus to a bank of sixteen 8-bit peripheral registers. The registers live behind a much slower clock that has no fixed phase relation to the processor clock. The bridge models where the slow clock sits inside its own cycle, and it holds the processor in wait states until the access has completed on the slow side. The number of wait states therefore changes from one access to the next. It follows from the slow-clock phase at the moment of the request. It is not a constant.

The slow phase comes from a fractional accumulator in the fast domain. Each fast cycle adds twice the slow frequency to the accumulator, modulo the fast frequency, and every wrap marks half a slow cycle. Take a request made in fast cycle c, where slow cycle v is running. The register transfer happens on the boundary that opens slow cycle v+1. The processor is released one fast cycle after the last fast cycle that lies at or before the middle of slow cycle v+1.

Register selection and lane handling work as follows:
- Address bits [11:8] pick the register.
- A write stores each enabled byte lane into that register in turn, low lane first.
- A read returns the register byte on both lanes.
- A read flagged as side-effect-free skips the synchronisation and does not strobe the peripheral.

The parameters must keep the fast clock at least eight times the slow clock.

The control state machine has seven states:
- IDLE waits for a request. It moves to PEEK for a debug read, to XFER_LO when the next slow boundary is the very next cycle, and to SYNC otherwise.
- SYNC waits for the slow boundary and then moves to XFER_LO.
- XFER_LO handles the low lane, or performs the peripheral read, and always moves to XFER_HI.
- XFER_HI handles the high lane and always moves to SETTLE.
- SETTLE raises ready at the release point and moves to IDLE.
- PEEK reads the register without a strobe and always moves to REPLY.
- REPLY raises ready and always moves to IDLE.

Top module: `slowbus_bridge`

## Requirements
- R1: Fast cycle 0 is the first cycle after reset is released. In fast cycle c the slow-cycle index is v = floor(c·F_SLOW/F_FAST), with no drift over any run length.
- R2: A synchronised access (any write, or a read with cpu_dbg=0) is sampled in cycle c. It raises cpu_ready in exactly one cycle, r = floor((2v+3)·F_FAST/(2·F_SLOW)) + 1, and cpu_ready is low in cycle r+1.
- R3: In a write, let b be the first cycle with b·F_SLOW ≥ (v+1)·F_FAST. In cycle b, per_wr pulses with per_wdata = cpu_wdata[7:0] if cpu_be[0]=1. In cycle b+1, per_wr pulses with cpu_wdata[15:8] if cpu_be[1]=1. No other per_wr pulse occurs, and when both lanes are enabled the high byte is the one that remains in the register.
- R4: per_sel equals cpu_addr[11:8] of the accepted request, and it holds that value for the whole access.
- R5: A synchronised read pulses per_rd only in cycle b. During the ready cycle, cpu_rdata carries the register byte on both lanes: {d,d}.
- R6: A read with cpu_dbg=1 sampled in cycle c raises cpu_ready in cycle c+2 with {d,d} on cpu_rdata and never pulses per_rd.
- R7: cpu_dbg has no effect on writes. A write with cpu_dbg=1 follows the timing of R2 and R3.
- R8: A request, or a change of request fields, while an access is in progress is ignored. It causes no strobe, changes no register and raises no additional ready.
- R9: While rst_n is low, cpu_ready, per_wr and per_rd are 0. Releasing reset restarts the phase at cycle 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Access request, sampled when idle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_dbg | input | 1 | Side-effect-free read flag |
| cpu_addr | input | ADDR_W | Byte address; bits [11:8] pick the register |
| cpu_be | input | 2 | Byte-lane enables for writes |
| cpu_wdata | input | 16 | Write data |
| cpu_rdata | output | 16 | Read data, replicated on both lanes |
| cpu_ready | output | 1 | One-cycle completion pulse |
| per_sel | output | 4 | Register index |
| per_wr | output | 1 | Register write strobe |
| per_rd | output | 1 | Register read strobe |
| per_wdata | output | 8 | Register write byte |
| per_rdata | input | 8 | Register read byte |

## Verification
Random stimulus mixes the following cases:
- reads and writes, so that both directions are shown to follow the same phase rule;
- all four byte-enable patterns, which separate a lane that is skipped from a lane that is written;
- the debug flag on reads and on writes, which shows the shortcut applies only to reads;
- requests held high with changing fields during an access, which exposes any re-triggering.

Directed cases target particular phases:
- a request in the first cycle after reset;
- a request one cycle before a slow boundary, where the transfer must happen on the next cycle;
- a request one cycle before a mid-cycle point.

These cases separate correct phase arithmetic from off-by-one rounding. A reset in the middle of an access shows that the accumulator restarts. A final debug sweep of all registers compares the stored contents with the expected model.

// File: rtl/sbb_pkg.sv
package sbb_pkg;
    localparam int LANES = 2;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SYNC,
        S_XFER_LO,
        S_XFER_HI,
        S_SETTLE,
        S_PEEK,
        S_REPLY
    } sbb_state_t;
endpackage

// File: rtl/sbb_phase.sv
module sbb_phase #(
    parameter int unsigned F_FAST = 15000000,
    parameter int unsigned F_SLOW = 783360
) (
    input  logic clk,
    input  logic rst_n,
    output logic wrap_o,
    output logic par_o,
    output logic acc_zero_o
);
    localparam longint unsigned STEP  = 2 * longint'(F_SLOW);
    localparam int              ACC_W = $clog2(longint'(F_FAST) + STEP + 1);
    localparam logic [ACC_W-1:0] STEP_V = ACC_W'(STEP);
    localparam logic [ACC_W-1:0] MOD_V  = ACC_W'(F_FAST);

    logic [ACC_W-1:0] acc_q, sum, acc_n;
    logic             par_q;

    always_comb begin
        sum    = acc_q + STEP_V;
        wrap_o = (sum >= MOD_V);
        acc_n  = wrap_o ? (sum - MOD_V) : sum;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            par_q <= 1'b0;
        end else begin
            acc_q <= acc_n;
            if (wrap_o) par_q <= ~par_q;
        end
    end

    assign par_o      = par_q;
    assign acc_zero_o = (acc_q == '0);

    assert_acc_bounded_R1: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q < MOD_V);
    assert_parity_on_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (par_q != $past(par_q)) |-> $past(wrap_o));
endmodule

// File: rtl/sbb_lanes.sv
module sbb_lanes import sbb_pkg::*; #(
    parameter int BYTE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  sbb_state_t              state,
    input  logic                    we_q,
    input  logic [LANES-1:0]        be_q,
    input  logic [BYTE_W*LANES-1:0] wdata_q,
    input  logic [BYTE_W-1:0]       per_rdata,
    output logic                    per_wr,
    output logic                    per_rd,
    output logic [BYTE_W-1:0]       per_wdata,
    output logic [BYTE_W*LANES-1:0] cpu_rdata
);
    logic              lane_act;
    logic              lane_hi;
    logic [BYTE_W-1:0] rd_q;

    always_comb begin
        lane_act  = (state == S_XFER_LO) || (state == S_XFER_HI);
        lane_hi   = (state == S_XFER_HI);
        per_wr    = lane_act && we_q && be_q[lane_hi];
        per_wdata = lane_hi ? wdata_q[BYTE_W +: BYTE_W] : wdata_q[0 +: BYTE_W];
        per_rd    = (state == S_XFER_LO) && !we_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rd_q <= '0;
        else if (((state == S_XFER_LO) && !we_q) || (state == S_PEEK))
            rd_q <= per_rdata;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_rep
        assign cpu_rdata[g*BYTE_W +: BYTE_W] = rd_q;
    end

    assert_hi_follows_lo_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_XFER_HI) |-> ($past(state) == S_XFER_LO));
endmodule

// File: rtl/slowbus_bridge.sv
module slowbus_bridge import sbb_pkg::*; #(
    parameter int unsigned F_FAST  = 15000000,
    parameter int unsigned F_SLOW  = 783360,
    parameter int          ADDR_W  = 12,
    parameter int          SEL_LSB = 8,
    parameter int          SEL_W   = 4,
    parameter int          BYTE_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cpu_req,
    input  logic                    cpu_we,
    input  logic                    cpu_dbg,
    input  logic [ADDR_W-1:0]       cpu_addr,
    input  logic [LANES-1:0]        cpu_be,
    input  logic [BYTE_W*LANES-1:0] cpu_wdata,
    output logic [BYTE_W*LANES-1:0] cpu_rdata,
    output logic                    cpu_ready,
    output logic [SEL_W-1:0]        per_sel,
    output logic                    per_wr,
    output logic                    per_rd,
    output logic [BYTE_W-1:0]       per_wdata,
    input  logic [BYTE_W-1:0]       per_rdata
);
    sbb_state_t state, state_n;
    logic [1:0] need_q, need_n, need_init;
    logic       wrap, par, acc_zero;

    logic [SEL_W-1:0]        sel_q;
    logic                    we_q;
    logic [LANES-1:0]        be_q;
    logic [BYTE_W*LANES-1:0] wdata_q;

    sbb_phase #(.F_FAST(F_FAST), .F_SLOW(F_SLOW)) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .wrap_o     (wrap),
        .par_o      (par),
        .acc_zero_o (acc_zero)
    );

    // Half-slow wraps still needed before the mid point of the next slow cycle
    always_comb need_init = (par ? 2'd2 : 2'd3) - {1'b0, wrap};

    // Next state
    always_comb begin
        state_n = state;
        need_n  = need_q;
        if (wrap && (need_q != 2'd0)) need_n = need_q - 2'd1;
        unique case (state)
            S_IDLE: begin
                if (cpu_req) begin
                    if (cpu_dbg && !cpu_we) begin
                        state_n = S_PEEK;
                    end else begin
                        need_n  = need_init;
                        state_n = (need_init == 2'd1) ? S_XFER_LO : S_SYNC;
                    end
                end
            end
            S_SYNC:    if (need_n == 2'd1) state_n = S_XFER_LO;
            S_XFER_LO: state_n = S_XFER_HI;
            S_XFER_HI: state_n = S_SETTLE;
            S_SETTLE:  if (cpu_ready) state_n = S_IDLE;
            S_PEEK:    state_n = S_REPLY;
            S_REPLY:   state_n = S_IDLE;
            default:   state_n = S_IDLE;
        endcase
    end

    // State register and request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            need_q  <= 2'd0;
            sel_q   <= '0;
            we_q    <= 1'b0;
            be_q    <= '0;
            wdata_q <= '0;
        end else begin
            state  <= state_n;
            need_q <= need_n;
            if ((state == S_IDLE) && cpu_req) begin
                sel_q   <= cpu_addr[SEL_LSB +: SEL_W];
                we_q    <= cpu_we;
                be_q    <= cpu_be;
                wdata_q <= cpu_wdata;
            end
        end
    end

    // Outputs
    always_comb begin
        cpu_ready = ((state == S_SETTLE) && (need_q == 2'd0) && !acc_zero)
                 || (state == S_REPLY);
        per_sel   = sel_q;
    end

    sbb_lanes #(.BYTE_W(BYTE_W)) u_lanes (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .we_q      (we_q),
        .be_q      (be_q),
        .wdata_q   (wdata_q),
        .per_rdata (per_rdata),
        .per_wr    (per_wr),
        .per_rd    (per_rd),
        .per_wdata (per_wdata),
        .cpu_rdata (cpu_rdata)
    );

    assert_ready_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);
    assert_xfer_on_boundary_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_XFER_LO) |-> $past(wrap) || $past(state) == S_IDLE && $past(wrap));
    assert_sel_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_IDLE) |=> $stable(per_sel));
    assert_peek_no_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_REPLY) |-> !$past(per_rd));
endmodule

// File: tb/sim_slowbus_bridge.sv
module sim_slowbus_bridge;
    localparam int     CLK_PERIOD = 10;
    localparam longint FF = 15000000;
    localparam longint FS = 783360;
    localparam int     WATCHDOG = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0, cpu_dbg = 1'b0;
    logic [11:0] cpu_addr = '0;
    logic [1:0]  cpu_be = '0;
    logic [15:0] cpu_wdata = '0;
    logic [15:0] cpu_rdata;
    logic        cpu_ready;
    logic [3:0]  per_sel;
    logic        per_wr, per_rd;
    logic [7:0]  per_wdata, per_rdata;

    logic [7:0]  regs [16];
    logic [7:0]  exp_regs [16];
    logic        load_init = 1'b1;
    longint      cyc;
    int          checks = 0, errors = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    slowbus_bridge u0 (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_dbg(cpu_dbg),
        .cpu_addr(cpu_addr), .cpu_be(cpu_be), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_ready(cpu_ready), .per_sel(per_sel), .per_wr(per_wr), .per_rd(per_rd),
        .per_wdata(per_wdata), .per_rdata(per_rdata)
    );

    // Peripheral register file model
    always @(posedge clk) begin
        if (load_init) begin
            for (int i = 0; i < 16; i++) regs[i] <= 8'(i * 37 + 5);
        end else if (per_wr) begin
            regs[per_sel] <= per_wdata;
        end
    end
    assign per_rdata = regs[per_sel];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic longint hidx(input longint c);
        return (2 * c * FS) / FF;
    endfunction

    // Called at a negedge; drives the request in the current cycle
    task automatic access(input bit we, input bit dbg, input logic [11:0] addr,
                          input logic [1:0] be, input logic [15:0] wd, input bit noisy);
        longint c, v, exp_r, b, got_r;
        bit peek;
        int lo_n, hi_n, rd_n, bad_n;
        logic [3:0] sel;
        logic [7:0] ed;
        string tag;
        c = cyc;
        v = (c * FS) / FF;
        peek = dbg && !we;
        sel = addr[11:8];
        ed = exp_regs[sel];
        exp_r = peek ? c + 2 : ((2 * v + 3) * FF) / (2 * FS) + 1;
        b = ((v + 1) * FF + FS - 1) / FS;
        tag = peek ? "R6" : (dbg ? "R7" : "R1 R2");
        cpu_req = 1'b1; cpu_we = we; cpu_dbg = dbg; cpu_addr = addr; cpu_be = be; cpu_wdata = wd;
        got_r = -1; lo_n = 0; hi_n = 0; rd_n = 0; bad_n = 0;
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            if (noisy) begin
                cpu_addr = 12'($urandom); cpu_we = 1'($urandom); cpu_be = 2'($urandom);
                cpu_wdata = 16'($urandom); cpu_dbg = 1'($urandom);
            end else begin
                cpu_req = 1'b0;
            end
            if (per_wr) begin
                if (!peek && we && cyc == b && be[0] && per_wdata == wd[7:0] && per_sel == sel) lo_n++;
                else if (!peek && we && cyc == b + 1 && be[1] && per_wdata == wd[15:8] && per_sel == sel) hi_n++;
                else bad_n++;
            end
            if (per_rd) begin
                if (!peek && !we && cyc == b && per_sel == sel) rd_n++;
                else bad_n++;
            end
            if (cpu_ready) begin
                got_r = cyc;
                break;
            end
        end
        cpu_req = 1'b0;
        chk(got_r == exp_r, tag, got_r, exp_r);
        if (!we) chk(cpu_rdata == {ed, ed}, peek ? "R6" : "R5", cpu_rdata, {ed, ed});
        if (we) begin
            chk(lo_n == int'(be[0]), "R3 low lane", lo_n, be[0]);
            chk(hi_n == int'(be[1]), "R3 high lane", hi_n, be[1]);
        end else begin
            chk(rd_n == (peek ? 0 : 1), peek ? "R6 strobe" : "R5 strobe", rd_n, peek ? 0 : 1);
        end
        chk(bad_n == 0, noisy ? "R8 stray strobe" : "R4 stray strobe", bad_n, 0);
        @(negedge clk);
        chk(!cpu_ready, noisy ? "R8 extra ready" : "R2 ready width", cpu_ready, 0);
        if (we) begin
            if (be[0]) exp_regs[sel] = wd[7:0];
            if (be[1]) exp_regs[sel] = wd[15:8];
        end
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd4242);
        for (int i = 0; i < 16; i++) exp_regs[i] = 8'(i * 37 + 5);
        repeat (3) @(negedge clk);
        chk(!cpu_ready && !per_wr && !per_rd, "R9 reset outputs", {cpu_ready, per_wr, per_rd}, 0);
        load_init = 1'b0;
        rst_n = 1'b1;
        // Request in cycle 0 (R1 origin)
        access(1'b0, 1'b0, 12'h300, 2'b00, 16'h0, 1'b0);
        // Write both lanes, high lane must be final (R3)
        @(negedge clk);
        access(1'b1, 1'b0, 12'h5A0, 2'b11, 16'hC3A5, 1'b0);
        // Request one cycle before a slow boundary
        @(negedge clk);
        while (!(hidx(cyc + 1) != hidx(cyc) && (hidx(cyc + 1) % 2) == 0)) @(negedge clk);
        access(1'b1, 1'b0, 12'h7FF, 2'b01, 16'h1177, 1'b0);
        // Request one cycle before a mid-slow-cycle point
        @(negedge clk);
        while (!(hidx(cyc + 1) != hidx(cyc) && (hidx(cyc + 1) % 2) == 1)) @(negedge clk);
        access(1'b0, 1'b0, 12'h700, 2'b00, 16'h0, 1'b0);
        // Debug flag on a write is ignored (R7), debug read (R6)
        @(negedge clk);
        access(1'b1, 1'b1, 12'h200, 2'b10, 16'h9900, 1'b0);
        @(negedge clk);
        access(1'b0, 1'b1, 12'h200, 2'b00, 16'h0, 1'b0);
        // Busy requests ignored (R8)
        @(negedge clk);
        access(1'b1, 1'b0, 12'h900, 2'b11, 16'h4321, 1'b1);
        // Reset during an access (R9)
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_dbg = 1'b0; cpu_addr = 12'h100;
        @(negedge clk); cpu_req = 1'b0;
        @(negedge clk); rst_n = 1'b0;
        repeat (3) begin
            @(negedge clk);
            chk(!cpu_ready && !per_wr && !per_rd, "R9 outputs in reset", {cpu_ready, per_wr, per_rd}, 0);
        end
        rst_n = 1'b1;
        access(1'b0, 1'b0, 12'hB00, 2'b00, 16'h0, 1'b0);
        // Random mix
        for (int n = 0; n < 70; n++) begin
            @(negedge clk);
            repeat ($urandom_range(0, 25)) @(negedge clk);
            access(1'($urandom), ($urandom % 4) == 0, 12'($urandom), 2'($urandom),
                   16'($urandom), ($urandom % 5) == 0);
        end
        // Sweep all registers through debug reads (R4, R6)
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            access(1'b0, 1'b1, {4'(i), 8'h3C}, 2'b00, 16'h0, 1'b0);
        end
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", WATCHDOG, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule